// File: doc/BRIEF.md
# Dual-Mode Serial Pin Adapter with Two-Wire Bus Support

This block sits between a shift-register serial engine and three device pins. A mode input chooses between two personalities. With the mode input low, the pins carry a plain synchronous/asynchronous serial link: transmit data out, receive data in, and a serial clock out. With the mode input high, the first two pins become an open-drain two-wire bus (data line and clock line) and the third pin becomes a general-purpose port.

In bus mode the adapter does the following:
- It passes both line inputs through majority-free stability filters.
- It recognises start and stop conditions and keeps a bus-busy flag.
- It counts clock pulses, samples the acknowledge level on the ninth rising clock edge, and raises an acknowledge or no-acknowledge event on the ninth falling edge.
- It holds each new data output bit back until the filtered clock has been low for a programmable number of cycles.

The engine's three interrupt outputs and its DMA request are re-purposed in bus mode:
- The collision interrupt carries start/stop events.
- The transmit interrupt carries no-acknowledge.
- The receive interrupt and the DMA request carry acknowledge.

A second select input returns the transmit, receive and DMA outputs to the ordinary engine sources.

Top module: `sio_busmode_adapter`

## Requirements
- R1: With bus_en=0, p0_oe=1 and p0_do=tx_bit, p1_oe=0, p2_oe=1 and p2_do=eng_sclk, and sclk_in follows p2_in.
- R2: With bus_en=1, p0_do=0 and p1_do=0 (open drain). p0_oe is 1 exactly when the delayed data bit is 0, p1_oe=eng_scl_low, p2_oe=gp_dir and p2_do=gp_out.
- R3: With bus_en=1, sclk_in gives the filtered level of p1_in even while the adapter itself drives p1 (p1_oe=1). rx_bit gives the filtered level of p0_in.
- R4: A filtered line changes only after its raw input has shown the new level at 3 consecutive clock samples; a 2-sample glitch has no effect on rx_bit or on condition detection.
- R5: With bus_en=1, a filtered data fall while the filtered clock is high gives a one-cycle irq_coll pulse and sets bus_busy on the next cycle.
- R6: With bus_en=1, a filtered data rise while the filtered clock is high gives a one-cycle irq_coll pulse and clears bus_busy.
- R7: After a start, the data level at the 9th filtered clock rise is the acknowledge bit. On the 9th filtered clock fall, a level of 0 gives one pulse on irq_rx and on dma_req, and a level of 1 gives one pulse on irq_tx.
- R8: When bus_en=0 or plain_irq_sel=1, irq_tx=uart_tx_ev, irq_rx=uart_rx_ev and dma_req=uart_rx_ev, and no acknowledge event reaches them.
- R9: irq_coll=uart_coll_ev when bus_en=0. When bus_en=1, uart_coll_ev has no effect on irq_coll.
- R10: While bus_busy=1, the delayed data bit changes only when the filtered clock is low: tx_bit is taken exactly sda_dly+1 cycles after the filtered clock falls, and it is held while the clock is high.
- R11: After reset, bus_busy=0, all event outputs are 0 and the delayed data bit is 1 (released).
- R12: Clearing bus_en clears bus_busy on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | 1 selects two-wire bus mode |
| plain_irq_sel | input | 1 | 1 keeps ordinary transmit/receive/DMA sources in bus mode |
| sda_dly | input | 4 | Data output hold-off in cycles after clock low |
| tx_bit | input | 1 | Engine shift-out bit |
| eng_sclk | input | 1 | Engine serial clock output (serial mode) |
| eng_scl_low | input | 1 | Engine request to hold the bus clock low |
| gp_dir | input | 1 | Port direction for pin 2 in bus mode |
| gp_out | input | 1 | Port output value for pin 2 in bus mode |
| uart_tx_ev | input | 1 | Ordinary transmit interrupt source |
| uart_rx_ev | input | 1 | Ordinary receive interrupt source |
| uart_coll_ev | input | 1 | Ordinary collision interrupt source |
| p0_in | input | 1 | Pin 0 level (data line) |
| p1_in | input | 1 | Pin 1 level (receive / bus clock) |
| p2_in | input | 1 | Pin 2 level (serial clock / port) |
| p0_oe | output | 1 | Pin 0 drive enable |
| p0_do | output | 1 | Pin 0 drive value |
| p1_oe | output | 1 | Pin 1 drive enable |
| p1_do | output | 1 | Pin 1 drive value |
| p2_oe | output | 1 | Pin 2 drive enable |
| p2_do | output | 1 | Pin 2 drive value |
| rx_bit | output | 1 | Filtered receive data to engine |
| sclk_in | output | 1 | Clock level seen by engine |
| irq_tx | output | 1 | Transmit / no-acknowledge event |
| irq_rx | output | 1 | Receive / acknowledge event |
| irq_coll | output | 1 | Collision / start-stop event |
| dma_req | output | 1 | DMA request |
| bus_busy | output | 1 | Bus busy flag |

## Verification
The assertions take for granted that data and clock never change at the same sample, so that a start or stop is never mixed up with a data bit. They also take for granted that the select inputs stay steady around an acknowledge event. The directed stimulus moves one line at a time and waits several cycles between changes, which is well beyond the filter window. It changes bus_en and plain_irq_sel only while the bus is idle. The glitch and delay cases place their edges on exact cycles, so that the filter window and the hold-off count are checked cycle by cycle.

// File: rtl/sio_bm_pkg.sv
package sio_bm_pkg;
  typedef struct packed {
    logic tx;
    logic rx;
    logic coll;
    logic dma;
  } sio_irq_t;

  typedef struct packed {
    logic oe;
    logic dout;
  } pin_drv_t;
endpackage

// File: rtl/sio_glitch_filter.sv
module sio_glitch_filter #(
  parameter int  SAMPLES = 3,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic din,
  output logic dout
);
  localparam int HW = SAMPLES - 1;

  logic [HW-1:0] hist_q, hist_d;
  logic          filt_q, filt_d;
  logic [HW:0]   win;

  always_comb begin
    win    = {hist_q, din};
    hist_d = win[HW-1:0];
    if (&win)       filt_d = 1'b1;
    else if (~|win) filt_d = 1'b0;
    else            filt_d = filt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= {HW{RST_VAL}};
      filt_q <= RST_VAL;
    end else if (smp_en) begin
      hist_q <= hist_d;
      filt_q <= filt_d;
    end
  end

  assign dout = filt_q;
endmodule

// File: rtl/sio_bus_cond.sv
module sio_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_en,
  input  logic sda_f,
  input  logic scl_f,
  output logic start_p,
  output logic stop_p,
  output logic scl_rise,
  output logic scl_fall,
  output logic busy
);
  logic sda_prev_q, scl_prev_q, busy_q, busy_d;

  always_comb begin
    start_p  = bus_en & scl_f & scl_prev_q & sda_prev_q & ~sda_f;
    stop_p   = bus_en & scl_f & scl_prev_q & ~sda_prev_q & sda_f;
    scl_rise = ~scl_prev_q & scl_f;
    scl_fall = scl_prev_q & ~scl_f;
    if (!bus_en)      busy_d = 1'b0;
    else if (stop_p)  busy_d = 1'b0;
    else if (start_p) busy_d = 1'b1;
    else              busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_prev_q <= 1'b1;
      scl_prev_q <= 1'b1;
      busy_q     <= 1'b0;
    end else begin
      sda_prev_q <= sda_f;
      scl_prev_q <= scl_f;
      busy_q     <= busy_d;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/sio_ack_sampler.sv
module sio_ack_sampler #(
  parameter int BITS = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic start_p,
  input  logic scl_rise,
  input  logic scl_fall,
  input  logic sda_f,
  output logic ack_p,
  output logic nack_p
);
  localparam int CW = $clog2(BITS + 1);
  localparam logic [CW-1:0] LAST = CW'(BITS);
  localparam logic [CW-1:0] PRE  = CW'(BITS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ackb_q, ackb_d;
  logic          at_end;

  always_comb begin
    at_end = scl_fall & (cnt_q == LAST);
    ack_p  = at_end & ~ackb_q;
    nack_p = at_end & ackb_q;
    cnt_d  = cnt_q;
    ackb_d = ackb_q;
    if (start_p || !busy) begin
      cnt_d = '0;
    end else if (at_end) begin
      cnt_d = '0;
    end else if (scl_rise && cnt_q != LAST) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == PRE) ackb_d = sda_f;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      ackb_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      ackb_q <= ackb_d;
    end
  end
endmodule

// File: rtl/sio_sda_delay.sv
module sio_sda_delay #(
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_en,
  input  logic          busy,
  input  logic          scl_f,
  input  logic [DW-1:0] dly,
  input  logic          tx_bit,
  output logic          sda_hold
);
  localparam logic [DW-1:0] CMAX = {DW{1'b1}};

  logic [DW-1:0] low_q, low_d;
  logic          hold_q, upd;

  always_comb begin
    if (scl_f)              low_d = '0;
    else if (low_q == CMAX) low_d = CMAX;
    else                    low_d = low_q + 1'b1;
    upd = ~bus_en | ~busy | (~scl_f & (low_q >= dly));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_q  <= '0;
      hold_q <= 1'b1;
    end else begin
      low_q <= low_d;
      if (upd) hold_q <= tx_bit;
    end
  end

  assign sda_hold = hold_q;
endmodule

// File: rtl/sio_busmode_adapter.sv
module sio_busmode_adapter
  import sio_bm_pkg::*;
#(
  parameter int FILT_SAMPLES = 3,
  parameter int DLY_W        = 4,
  parameter int FRAME_BITS   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             plain_irq_sel,
  input  logic [DLY_W-1:0] sda_dly,
  input  logic             tx_bit,
  input  logic             eng_sclk,
  input  logic             eng_scl_low,
  input  logic             gp_dir,
  input  logic             gp_out,
  input  logic             uart_tx_ev,
  input  logic             uart_rx_ev,
  input  logic             uart_coll_ev,
  input  logic             p0_in,
  input  logic             p1_in,
  input  logic             p2_in,
  output logic             p0_oe,
  output logic             p0_do,
  output logic             p1_oe,
  output logic             p1_do,
  output logic             p2_oe,
  output logic             p2_do,
  output logic             rx_bit,
  output logic             sclk_in,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_coll,
  output logic             dma_req,
  output logic             bus_busy
);
  localparam int NLINES = 2;

  logic [1:0] rsync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  // line 0 = pin 0 (data), line 1 = pin 1 (clock / receive)
  logic [NLINES-1:0] raw_in, filt;
  assign raw_in = {p1_in, p0_in};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    sio_glitch_filter #(.SAMPLES(FILT_SAMPLES), .RST_VAL(1'b1)) u_filt (
      .clk   (clk),
      .rst_n (rst_sn),
      .smp_en(1'b1),
      .din   (raw_in[g]),
      .dout  (filt[g])
    );
  end

  logic sda_f, scl_f;
  assign sda_f = filt[0];
  assign scl_f = filt[1];

  logic start_p, stop_p, scl_rise, scl_fall, busy;

  sio_bus_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_sn),
    .bus_en  (bus_en),
    .sda_f   (sda_f),
    .scl_f   (scl_f),
    .start_p (start_p),
    .stop_p  (stop_p),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .busy    (busy)
  );

  logic ack_p, nack_p;

  sio_ack_sampler #(.BITS(FRAME_BITS)) u_ack (
    .clk     (clk),
    .rst_n   (rst_sn),
    .busy    (busy),
    .start_p (start_p),
    .scl_rise(scl_rise),
    .scl_fall(scl_fall),
    .sda_f   (sda_f),
    .ack_p   (ack_p),
    .nack_p  (nack_p)
  );

  logic sda_hold;

  sio_sda_delay #(.DW(DLY_W)) u_dly (
    .clk     (clk),
    .rst_n   (rst_sn),
    .bus_en  (bus_en),
    .busy    (busy),
    .scl_f   (scl_f),
    .dly     (sda_dly),
    .tx_bit  (tx_bit),
    .sda_hold(sda_hold)
  );

  pin_drv_t pd0, pd1, pd2;
  sio_irq_t irq;
  logic     route_bus;

  always_comb begin
    route_bus = bus_en & ~plain_irq_sel;
    if (bus_en) begin
      pd0     = '{oe: ~sda_hold,   dout: 1'b0};
      pd1     = '{oe: eng_scl_low, dout: 1'b0};
      pd2     = '{oe: gp_dir,      dout: gp_out};
      rx_bit  = sda_f;
      sclk_in = scl_f;
    end else begin
      pd0     = '{oe: 1'b1, dout: tx_bit};
      pd1     = '{oe: 1'b0, dout: 1'b0};
      pd2     = '{oe: 1'b1, dout: eng_sclk};
      rx_bit  = scl_f;
      sclk_in = p2_in;
    end
    irq.coll = bus_en ? (start_p | stop_p) : uart_coll_ev;
    if (route_bus) begin
      irq.tx  = nack_p;
      irq.rx  = ack_p;
      irq.dma = ack_p;
    end else begin
      irq.tx  = uart_tx_ev;
      irq.rx  = uart_rx_ev;
      irq.dma = uart_rx_ev;
    end
  end

  assign p0_oe    = pd0.oe;
  assign p0_do    = pd0.dout;
  assign p1_oe    = pd1.oe;
  assign p1_do    = pd1.dout;
  assign p2_oe    = pd2.oe;
  assign p2_do    = pd2.dout;
  assign irq_tx   = irq.tx;
  assign irq_rx   = irq.rx;
  assign irq_coll = irq.coll;
  assign dma_req  = irq.dma;
  assign bus_busy = busy;
endmodule

// File: rtl/sio_busmode_adapter_chk.sv
module sio_busmode_adapter_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_en,
  input logic plain_irq_sel,
  input logic p1_in,
  input logic p0_oe,
  input logic p0_do,
  input logic p1_do,
  input logic irq_tx,
  input logic irq_rx,
  input logic bus_busy,
  input logic start_p,
  input logic stop_p,
  input logic ack_p,
  input logic scl_f
);
  // R5
  busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_busy) |-> $past(start_p));

  // R6
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !bus_busy);

  // R7
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !plain_irq_sel) |-> !(irq_tx && irq_rx));

  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_p |=> !ack_p);

  // R2
  open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en |-> (!p0_do && !p1_do));

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && $past(bus_en) && $past(bus_busy) && $past(scl_f)) |-> $stable(p0_oe));

  // R4
  filt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_f) |-> ($past(p1_in) == scl_f && $past(p1_in, 2) == scl_f));
endmodule

bind sio_busmode_adapter sio_busmode_adapter_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sn),
  .bus_en       (bus_en),
  .plain_irq_sel(plain_irq_sel),
  .p1_in        (p1_in),
  .p0_oe        (p0_oe),
  .p0_do        (p0_do),
  .p1_do        (p1_do),
  .irq_tx       (irq_tx),
  .irq_rx       (irq_rx),
  .bus_busy     (bus_busy),
  .start_p      (start_p),
  .stop_p       (stop_p),
  .ack_p        (ack_p),
  .scl_f        (scl_f)
);

// File: tb/sio_busmode_adapter_bench.sv
module sio_busmode_adapter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, plain_irq_sel = 1'b0;
  logic [3:0] sda_dly = 4'd0;
  logic tx_bit = 1'b1, eng_sclk = 1'b0, eng_scl_low = 1'b0;
  logic gp_dir = 1'b0, gp_out = 1'b0;
  logic uart_tx_ev = 1'b0, uart_rx_ev = 1'b0, uart_coll_ev = 1'b0;
  logic p0_in = 1'b1, p1_in = 1'b1, p2_in = 1'b0;
  logic p0_oe, p0_do, p1_oe, p1_do, p2_oe, p2_do, rx_bit, sclk_in;
  logic irq_tx, irq_rx, irq_coll, dma_req, bus_busy;

  int checks = 0, fails = 0;
  int n_tx = 0, n_rx = 0, n_coll = 0, n_dma = 0;

  always #5 clk = ~clk;

  sio_busmode_adapter u_sio_busmode_adapter (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .plain_irq_sel(plain_irq_sel),
    .sda_dly(sda_dly), .tx_bit(tx_bit), .eng_sclk(eng_sclk), .eng_scl_low(eng_scl_low),
    .gp_dir(gp_dir), .gp_out(gp_out), .uart_tx_ev(uart_tx_ev), .uart_rx_ev(uart_rx_ev),
    .uart_coll_ev(uart_coll_ev), .p0_in(p0_in), .p1_in(p1_in), .p2_in(p2_in),
    .p0_oe(p0_oe), .p0_do(p0_do), .p1_oe(p1_oe), .p1_do(p1_do), .p2_oe(p2_oe),
    .p2_do(p2_do), .rx_bit(rx_bit), .sclk_in(sclk_in), .irq_tx(irq_tx), .irq_rx(irq_rx),
    .irq_coll(irq_coll), .dma_req(dma_req), .bus_busy(bus_busy)
  );

  always @(negedge clk) begin
    if (irq_tx)   n_tx++;
    if (irq_rx)   n_rx++;
    if (irq_coll) n_coll++;
    if (dma_req)  n_dma++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_sda(input logic v);
    p0_in = v; wait_n(5);
  endtask

  task automatic set_scl(input logic v);
    p1_in = v; wait_n(5);
  endtask

  task automatic do_start();
    set_sda(1'b0);
  endtask

  task automatic do_stop();
    set_sda(1'b0); set_scl(1'b1); set_sda(1'b1);
  endtask

  // after a start: nine clock pulses, last data level = ackv
  task automatic clock_frame(input logic ackv);
    set_scl(1'b0);
    for (int b = 0; b < 9; b++) begin
      set_sda(b == 8 ? ackv : logic'(b % 2));
      set_scl(1'b1);
      set_scl(1'b0);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wait_n(3);
    chk("R11", "busy in reset", int'(bus_busy), 0);
    rst_n = 1'b1; wait_n(4);
    chk("R11", "busy after reset", int'(bus_busy), 0);
    chk("R11", "events after reset", int'({irq_tx, irq_rx, irq_coll, dma_req}), 0);
    bus_en = 1'b1; wait_n(1);
    chk("R11", "data released after reset", int'(p0_oe), 0);
    bus_en = 1'b0; wait_n(1);
  endtask

  task automatic t_serial_map();
    bus_en = 1'b0; tx_bit = 1'b0; eng_sclk = 1'b1; p2_in = 1'b1; wait_n(1);
    chk("R1", "p0_oe", int'(p0_oe), 1);
    chk("R1", "p0_do low", int'(p0_do), 0);
    chk("R1", "p1_oe", int'(p1_oe), 0);
    chk("R1", "p2 drive", int'({p2_oe, p2_do}), 3);
    chk("R1", "sclk_in", int'(sclk_in), 1);
    tx_bit = 1'b1; eng_sclk = 1'b0; p2_in = 1'b0; wait_n(1);
    chk("R1", "p0_do high", int'(p0_do), 1);
    chk("R1", "p2_do low", int'(p2_do), 0);
    chk("R1", "sclk_in low", int'(sclk_in), 0);
  endtask

  task automatic t_route_plain();
    int c0;
    bus_en = 1'b0;
    uart_tx_ev = 1'b1; uart_rx_ev = 1'b1; uart_coll_ev = 1'b1; wait_n(1);
    chk("R8", "serial tx route", int'(irq_tx), 1);
    chk("R8", "serial rx/dma route", int'({irq_rx, dma_req}), 3);
    chk("R9", "serial coll route", int'(irq_coll), 1);
    uart_tx_ev = 1'b0; uart_rx_ev = 1'b0; uart_coll_ev = 1'b0; wait_n(1);
    bus_en = 1'b1; uart_coll_ev = 1'b1; c0 = n_coll; wait_n(4);
    chk("R9", "uart coll ignored in bus mode", n_coll - c0, 0);
    uart_coll_ev = 1'b0;
    plain_irq_sel = 1'b1; uart_tx_ev = 1'b1; wait_n(1);
    chk("R8", "plain select tx", int'(irq_tx), 1);
    uart_tx_ev = 1'b0; wait_n(1);
  endtask

  task automatic t_bus_map();
    bus_en = 1'b1; plain_irq_sel = 1'b0; gp_dir = 1'b1; gp_out = 1'b1; eng_scl_low = 1'b1;
    wait_n(1);
    chk("R2", "open drain values", int'({p0_do, p1_do}), 0);
    chk("R2", "p1_oe follows engine", int'(p1_oe), 1);
    chk("R2", "gp port", int'({p2_oe, p2_do}), 3);
    p1_in = 1'b0; wait_n(4);
    chk("R3", "clock readable while driven", int'(sclk_in), 0);
    p1_in = 1'b1; wait_n(4);
    chk("R3", "clock readable high", int'(sclk_in), 1);
    eng_scl_low = 1'b0; gp_dir = 1'b0; wait_n(1);
    chk("R2", "gp dir off", int'(p2_oe), 0);
  endtask

  task automatic t_filter();
    int c0;
    bus_en = 1'b1; c0 = n_coll;
    p0_in = 1'b0; @(posedge clk); @(posedge clk); @(negedge clk);
    p0_in = 1'b1; wait_n(4);
    chk("R4", "glitch rx_bit", int'(rx_bit), 1);
    chk("R4", "glitch gives no condition", n_coll - c0, 0);
    p0_in = 1'b0; @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R4", "two samples not enough", int'(rx_bit), 1);
    @(posedge clk); @(negedge clk);
    chk("R4", "third sample changes", int'(rx_bit), 0);
    wait_n(3);
    chk("R5", "start pulse count", n_coll - c0, 1);
    chk("R5", "busy after start", int'(bus_busy), 1);
    set_sda(1'b1);
    chk("R6", "stop pulse count", n_coll - c0, 2);
    chk("R6", "busy after stop", int'(bus_busy), 0);
  endtask

  task automatic t_ack(input logic ackv);
    int t0, r0, d0;
    bus_en = 1'b1; plain_irq_sel = 1'b0;
    t0 = n_tx; r0 = n_rx; d0 = n_dma;
    do_start();
    chk("R5", "busy set", int'(bus_busy), 1);
    clock_frame(ackv);
    chk("R7", ackv ? "nack tx count" : "ack tx count", n_tx - t0, ackv ? 1 : 0);
    chk("R7", ackv ? "nack rx count" : "ack rx count", n_rx - r0, ackv ? 0 : 1);
    chk("R7", "dma count", n_dma - d0, ackv ? 0 : 1);
    do_stop();
    chk("R6", "idle after frame", int'(bus_busy), 0);
  endtask

  task automatic t_ack_plain();
    int r0, d0;
    bus_en = 1'b1; plain_irq_sel = 1'b1; r0 = n_rx; d0 = n_dma;
    do_start(); clock_frame(1'b0); do_stop();
    chk("R8", "no ack event with plain select", n_rx - r0, 0);
    chk("R8", "no dma with plain select", n_dma - d0, 0);
    plain_irq_sel = 1'b0; wait_n(1);
  endtask

  task automatic t_delay(input logic [3:0] d);
    int j;
    bus_en = 1'b1; sda_dly = d; tx_bit = 1'b1; wait_n(2);
    do_start();
    tx_bit = 1'b0; wait_n(6);
    chk("R10", "held while clock high", int'(p0_oe), 0);
    p1_in = 1'b0;
    j = 0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); @(negedge clk);
      if (p0_oe && j == 0) j = k + 1;
    end
    chk("R10", $sformatf("hold-off edges dly=%0d", d), j, int'(d) + 4);
    tx_bit = 1'b1; wait_n(2);
    set_scl(1'b1);
    bus_en = 1'b0; wait_n(1);
    chk("R12", "busy cleared on exit", int'(bus_busy), 0);
    p0_in = 1'b1; wait_n(4);
    bus_en = 1'b1; wait_n(1);
    chk("R12", "stays idle on re-entry", int'(bus_busy), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_serial_map();
    t_route_plain();
    t_bus_map();
    t_filter();
    t_ack(1'b0);
    t_ack(1'b1);
    t_ack_plain();
    t_delay(4'd0);
    t_delay(4'd5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule